// File: doc/BRIEF.md
# Timer/Counter Slice with PWM and Tone Modes

This block is a single timer/counter built around a low count byte and a high count byte, both loaded and read back through a small register interface. In its counting family it runs as a timer (one step per clock) or as an event counter (one step per synchronised falling edge of an external input). Four counting arrangements are available: a counter with a programmable low-field width, a full 16-bit counter, an 8-bit counter with automatic reload from the high byte, and a plain 8-bit low-byte counter.

With the PWM family selected, the same registers drive a waveform output. The output can be an 8-bit pulse-width signal with a power-of-two prescaler, an unprescaled 8-bit pulse-width signal, or a square wave whose half period is set by the high byte. A hold mode freezes both the count and the output. A sticky overflow flag records every wrap until software clears it.

The mode is chosen with `pwm_en` (family) and `mode_sel` (00, 01, 10, 11 within the family). The 3-bit `shape_sel` sets the low-field width in counting mode 00 and the prescaler exponent in PWM mode 00.

Top module: `tmr_pwm_slice`

## Requirements
- R1: After reset, both count bytes read 0, the overflow flag is 0 and the wave output is 0.
- R2: A write strobe loads `wr_data` into the selected byte on the next clock; in any cycle with a write strobe, no counting, reload, toggle or overflow happens.
- R3: Counting mode 01 (`pwm_en`=0) steps the 16-bit value {high,low} by one per tick; the step from FFFFh to 0000h sets the overflow flag, which stays set until `ovf_clr`, and a wrap in the same cycle as `ovf_clr` leaves the flag set.
- R4: Counting mode 00 steps only the low `shape_sel`+1 bits of the low byte; when that field is all ones it clears (other low-byte bits unchanged) and the high byte steps by one; the flag is set when the high byte wraps from FFh at that moment.
- R5: Counting mode 10 steps the low byte; a tick with the low byte at FFh loads it from the high byte and sets the flag.
- R6: Counting mode 11 steps the low byte from FFh to 00h (setting the flag) and leaves the high byte untouched.
- R7: With `cnt_src`=1 each falling edge of `evt_in` gives one tick; the step is visible on the third rising clock edge after the input falls, and a steady or rising input gives none.
- R8: With `run_en`=0 no byte changes except through a write.
- R9: PWM mode 01 steps the low byte per tick (flag on FFh wrap); one clock after any cycle, `wave_out` is 1 exactly when low < high, so high = 0 gives a constant 0.
- R10: PWM mode 00 steps the low byte as a prescaler; a hidden 8-bit ramp steps on ticks where the low `shape_sel` bits of the low byte are all ones (every 2^N ticks, N = `shape_sel`), setting the flag when the ramp wraps; `wave_out` follows ramp < high one clock later.
- R11: PWM mode 10: a tick with low = high clears the low byte, inverts `wave_out` on the next edge and sets the flag; any other tick steps the low byte.
- R12: PWM mode 11 keeps both bytes and `wave_out` unchanged.
- R13: In every counting mode `wave_out` is 0 one clock after the mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | External event input, asynchronous |
| run_en | input | 1 | Enables counting |
| cnt_src | input | 1 | 0: tick every clock, 1: tick per falling edge of evt_in |
| pwm_en | input | 1 | 0: counting family, 1: PWM family |
| mode_sel | input | 2 | Mode within the selected family |
| shape_sel | input | 3 | Field width select (counting 00) or prescale exponent (PWM 00) |
| wr_lo | input | 1 | Load low byte from wr_data |
| wr_hi | input | 1 | Load high byte from wr_data |
| wr_data | input | 8 | Write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| wave_out | output | 1 | PWM / square wave output |
| cnt_lo | output | 8 | Low byte readback |
| cnt_hi | output | 8 | High byte readback |

## Verification
The assertions watch, on every cycle, the stickiness of the overflow flag, the freezing of both bytes when no tick or write occurs and in the hold mode, the reload value in mode 10, the one-cycle toggle after a match, a zero duty giving a low output, the low output in counting modes and that edge detection never fires twice in a row. Only the bench scenarios show the exact count sequences: the variable-width carry into the high byte, the prescaler spacing of the ramp for different exponents, the three-clock latency of event counting and the duty pattern over whole ramp periods.

// File: rtl/tmr_pwm_pkg.sv
package tmr_pwm_pkg;
   typedef enum logic [1:0] {
      MD_0 = 2'd0,
      MD_1 = 2'd1,
      MD_2 = 2'd2,
      MD_3 = 2'd3
   } tmr_mode_e;
endpackage

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_in,
   output logic fall_pulse
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_evt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= evt_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[i] <= 1'b1;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign fall_pulse = prev_q & ~sync_q[STAGES-1];

   // R7: one edge cannot be detected on two successive cycles
   p_single_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core
   import tmr_pwm_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              pwm_en,
   input  tmr_mode_e         mode,
   input  logic [SEL_W-1:0]  shape_sel,
   output logic [BYTE_W-1:0] lo_q,
   output logic [BYTE_W-1:0] hi_q,
   output logic [BYTE_W-1:0] ramp_q,
   output logic              ovf_evt,
   output logic              match_evt
);
   generate
      if (BYTE_W != (1 << SEL_W)) begin : g_bad_width
         $error("tmr_cnt_core: BYTE_W must equal 2**SEL_W");
      end
   endgenerate

   localparam logic [BYTE_W-1:0]   MAXV = {BYTE_W{1'b1}};
   localparam logic [BYTE_W-1:0]   ONE  = BYTE_W'(1);
   localparam logic [2*BYTE_W-1:0] ONEW = (2*BYTE_W)'(1);
   localparam logic [SEL_W-1:0]    LAST = SEL_W'(BYTE_W - 1);

   logic [BYTE_W-1:0]   lo_n, hi_n, ramp_n;
   logic [BYTE_W-1:0]   fmask, pmask;
   logic [2*BYTE_W-1:0] wide_n;
   logic                any_wr;

   assign fmask  = MAXV >> (LAST - shape_sel);
   assign pmask  = ~(MAXV << shape_sel);
   assign wide_n = {hi_q, lo_q} + ONEW;
   assign any_wr = wr_lo | wr_hi;

   always_comb begin
      lo_n      = lo_q;
      hi_n      = hi_q;
      ramp_n    = ramp_q;
      ovf_evt   = 1'b0;
      match_evt = 1'b0;
      if (any_wr) begin
         if (wr_lo) lo_n = wr_data;
         if (wr_hi) hi_n = wr_data;
      end else if (tick) begin
         if (!pwm_en) begin
            unique case (mode)
               MD_0: begin
                  if ((lo_q & fmask) == fmask) begin
                     lo_n    = lo_q & ~fmask;
                     hi_n    = hi_q + ONE;
                     ovf_evt = (hi_q == MAXV);
                  end else begin
                     lo_n = lo_q + ONE;
                  end
               end
               MD_1: begin
                  {hi_n, lo_n} = wide_n;
                  ovf_evt      = (lo_q == MAXV) && (hi_q == MAXV);
               end
               MD_2: begin
                  if (lo_q == MAXV) begin
                     lo_n    = hi_q;
                     ovf_evt = 1'b1;
                  end else begin
                     lo_n = lo_q + ONE;
                  end
               end
               MD_3: begin
                  lo_n    = lo_q + ONE;
                  ovf_evt = (lo_q == MAXV);
               end
               default: ;
            endcase
         end else begin
            unique case (mode)
               MD_0: begin
                  lo_n = lo_q + ONE;
                  if ((lo_q & pmask) == pmask) begin
                     ramp_n  = ramp_q + ONE;
                     ovf_evt = (ramp_q == MAXV);
                  end
               end
               MD_1: begin
                  lo_n    = lo_q + ONE;
                  ovf_evt = (lo_q == MAXV);
               end
               MD_2: begin
                  if (lo_q == hi_q) begin
                     lo_n      = '0;
                     match_evt = 1'b1;
                     ovf_evt   = 1'b1;
                  end else begin
                     lo_n = lo_q + ONE;
                  end
               end
               MD_3: ;
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         ramp_q <= '0;
      end else begin
         lo_q   <= lo_n;
         hi_q   <= hi_n;
         ramp_q <= ramp_n;
      end
   end

   // R8: without a tick or a write both bytes and the ramp stay put
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !any_wr) |=> ($stable(lo_q) && $stable(hi_q) && $stable(ramp_q)));

   // R12: the hold mode never moves the count
   p_pwm_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && mode == MD_3 && !any_wr) |=> ($stable(lo_q) && $stable(hi_q)));

   // R5: a reload takes the value the high byte had
   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !any_wr && !pwm_en && mode == MD_2 && lo_q == MAXV)
      |=> (lo_q == $past(hi_q)));

   // R2: a write lands in the addressed byte
   p_write_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (lo_q == $past(wr_data)));
endmodule

// File: rtl/tmr_wave_gen.sv
module tmr_wave_gen
   import tmr_pwm_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_en,
   input  tmr_mode_e         mode,
   input  logic [BYTE_W-1:0] lo_q,
   input  logic [BYTE_W-1:0] hi_q,
   input  logic [BYTE_W-1:0] ramp_q,
   input  logic              match_evt,
   output logic              wave_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wave_q <= 1'b0;
      end else if (!pwm_en) begin
         wave_q <= 1'b0;
      end else begin
         unique case (mode)
            MD_0: wave_q <= (ramp_q < hi_q);
            MD_1: wave_q <= (lo_q < hi_q);
            MD_2: if (match_evt) wave_q <= ~wave_q;
            MD_3: wave_q <= wave_q;
            default: wave_q <= wave_q;
         endcase
      end
   end

   // R13: counting family keeps the output low
   p_count_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_en |=> !wave_q);

   // R9: zero duty gives a low output
   p_duty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && mode == MD_1 && hi_q == '0) |=> !wave_q);

   // R11: a match flips the output on the next edge
   p_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> (wave_q != $past(wave_q)));
endmodule

// File: rtl/tmr_pwm_slice.sv
module tmr_pwm_slice
   import tmr_pwm_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_in,
   input  logic              run_en,
   input  logic              cnt_src,
   input  logic              pwm_en,
   input  logic [1:0]        mode_sel,
   input  logic [SEL_W-1:0]  shape_sel,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              ovf_clr,
   output logic              ovf_flag,
   output logic              wave_out,
   output logic [BYTE_W-1:0] cnt_lo,
   output logic [BYTE_W-1:0] cnt_hi
);
   logic              fall_pulse, tick, ovf_evt, match_evt;
   logic [BYTE_W-1:0] ramp_q;
   tmr_mode_e         mode;

   assign mode = tmr_mode_e'(mode_sel);
   assign tick = run_en & (cnt_src ? fall_pulse : 1'b1);

   tmr_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_in     (evt_in),
      .fall_pulse (fall_pulse)
   );

   tmr_cnt_core #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wr_lo     (wr_lo),
      .wr_hi     (wr_hi),
      .wr_data   (wr_data),
      .pwm_en    (pwm_en),
      .mode      (mode),
      .shape_sel (shape_sel),
      .lo_q      (cnt_lo),
      .hi_q      (cnt_hi),
      .ramp_q    (ramp_q),
      .ovf_evt   (ovf_evt),
      .match_evt (match_evt)
   );

   tmr_wave_gen #(.BYTE_W(BYTE_W)) u_wave (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwm_en    (pwm_en),
      .mode      (mode),
      .lo_q      (cnt_lo),
      .hi_q      (cnt_hi),
      .ramp_q    (ramp_q),
      .match_evt (match_evt),
      .wave_q    (wave_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       ovf_flag <= 1'b0;
      else if (ovf_evt) ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
   end

   // R3: the flag survives until software clears it
   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

   // R3: a wrap always leaves the flag set
   p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_flag);
endmodule

// File: tb/sim_tmr_pwm_slice.sv
module sim_tmr_pwm_slice;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_in = 1'b1, run_en = 1'b0, cnt_src = 1'b0, pwm_en = 1'b0;
   logic [1:0] mode_sel = 2'd0;
   logic [2:0] shape_sel = 3'd0;
   logic       wr_lo = 1'b0, wr_hi = 1'b0, ovf_clr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       ovf_flag, wave_out;
   logic [7:0] cnt_lo, cnt_hi;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;
   string cur_req = "R1";

   // model state
   logic [7:0] m_lo = 0, m_hi = 0, m_ramp = 0;
   logic       m_ovf = 0, m_wave = 0;
   logic       m_s1 = 1, m_s2 = 1, m_prev = 1;

   logic [17:0] exp_q[$];
   string       req_q[$];

   always #10 clk = ~clk;

   tmr_pwm_slice u0 (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .run_en(run_en),
      .cnt_src(cnt_src), .pwm_en(pwm_en), .mode_sel(mode_sel),
      .shape_sel(shape_sel), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wr_data(wr_data), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
      .wave_out(wave_out), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
   );

   function automatic void compare(string req, logic [17:0] act, logic [17:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual lo=%h hi=%h ovf=%b wave=%b expected lo=%h hi=%h ovf=%b wave=%b",
                  req, act[17:10], act[9:2], act[1], act[0],
                  exp[17:10], exp[9:2], exp[1], exp[0]);
      end
   endfunction

   // monitor: pops one expected item per clock
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         compare(req_q.pop_front(), {cnt_lo, cnt_hi, ovf_flag, wave_out}, exp_q.pop_front());
      end
   end

   // driver: advance the model by one edge with the present inputs
   task automatic cyc();
      logic [7:0] n_lo, n_hi, n_ramp, fm, pm;
      logic       fall, tick, ev, mt, n_wave;
      int         w;
      fall = m_prev & ~m_s2;
      tick = run_en & (cnt_src ? fall : 1'b1);
      n_lo = m_lo; n_hi = m_hi; n_ramp = m_ramp; ev = 0; mt = 0;
      w  = int'(shape_sel) + 1;
      fm = 8'((1 << w) - 1);
      pm = 8'((1 << shape_sel) - 1);
      if (wr_lo || wr_hi) begin
         if (wr_lo) n_lo = wr_data;
         if (wr_hi) n_hi = wr_data;
      end else if (tick) begin
         if (!pwm_en) begin
            case (mode_sel)
               2'd0: if ((m_lo & fm) == fm) begin
                        n_lo = m_lo & ~fm; n_hi = m_hi + 8'd1; ev = (m_hi == 8'hFF);
                     end else n_lo = m_lo + 8'd1;
               2'd1: begin {n_hi, n_lo} = {m_hi, m_lo} + 16'd1; ev = ({m_hi, m_lo} == 16'hFFFF); end
               2'd2: if (m_lo == 8'hFF) begin n_lo = m_hi; ev = 1; end else n_lo = m_lo + 8'd1;
               default: begin n_lo = m_lo + 8'd1; ev = (m_lo == 8'hFF); end
            endcase
         end else begin
            case (mode_sel)
               2'd0: begin
                  n_lo = m_lo + 8'd1;
                  if ((m_lo & pm) == pm) begin n_ramp = m_ramp + 8'd1; ev = (m_ramp == 8'hFF); end
               end
               2'd1: begin n_lo = m_lo + 8'd1; ev = (m_lo == 8'hFF); end
               2'd2: if (m_lo == m_hi) begin n_lo = 0; mt = 1; ev = 1; end else n_lo = m_lo + 8'd1;
               default: ;
            endcase
         end
      end
      if (!pwm_en) n_wave = 0;
      else case (mode_sel)
         2'd0: n_wave = (m_ramp < m_hi);
         2'd1: n_wave = (m_lo < m_hi);
         2'd2: n_wave = mt ? ~m_wave : m_wave;
         default: n_wave = m_wave;
      endcase
      m_ovf  = ev ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
      m_lo = n_lo; m_hi = n_hi; m_ramp = n_ramp; m_wave = n_wave;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = evt_in;
      @(posedge clk);
      #2;
      exp_q.push_back({m_lo, m_hi, m_ovf, m_wave});
      req_q.push_back(cur_req);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic load(logic [7:0] lo, logic [7:0] hi);
      wr_lo = 1; wr_data = lo; cyc(); wr_lo = 0;
      wr_hi = 1; wr_data = hi; cyc(); wr_hi = 0;
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      compare("R1", {cnt_lo, cnt_hi, ovf_flag, wave_out}, 18'd0);
      @(posedge clk); #2;

      // R2: loads with the counter stopped, then a write while running
      cur_req = "R2";
      load(8'h12, 8'h34); run(2);
      mode_sel = 2'd1; run_en = 1;
      wr_lo = 1; wr_data = 8'h40; cyc(); wr_lo = 0; run(2);

      // R3: 16-bit wrap and sticky flag, clear, set-wins
      cur_req = "R3";
      run_en = 0; load(8'hFD, 8'hFF); run_en = 1; run(5);
      ovf_clr = 1; cyc(); ovf_clr = 0; run(2);
      run_en = 0; load(8'hFF, 8'hFF); run_en = 1; ovf_clr = 1; cyc(); ovf_clr = 0; run(2);
      ovf_clr = 1; cyc(); ovf_clr = 0;

      // R4: variable-width field of 3 bits, then of 1 bit with high wrap
      cur_req = "R4";
      run_en = 0; mode_sel = 2'd0; shape_sel = 3'd2; load(8'hF5, 8'h10);
      run_en = 1; run(12);
      run_en = 0; shape_sel = 3'd0; load(8'hA0, 8'hFF); run_en = 1; run(4);
      ovf_clr = 1; cyc(); ovf_clr = 0;

      // R5: auto-reload
      cur_req = "R5";
      run_en = 0; mode_sel = 2'd2; load(8'hFD, 8'hFC); run_en = 1; run(10);
      ovf_clr = 1; cyc(); ovf_clr = 0;

      // R6: low-byte only counter
      cur_req = "R6";
      run_en = 0; mode_sel = 2'd3; load(8'hFE, 8'h55); run_en = 1; run(4);
      ovf_clr = 1; cyc(); ovf_clr = 0;

      // R7: event counting on falling edges
      cur_req = "R7";
      run_en = 0; mode_sel = 2'd1; load(8'h00, 8'h00); cnt_src = 1; run_en = 1;
      for (int k = 0; k < 3; k++) begin
         evt_in = 0; run(4);
         evt_in = 1; run(5);
      end
      run(3); cnt_src = 0;

      // R8: stopped counter holds
      cur_req = "R8";
      run_en = 0; run(5);

      // R9: PWM without prescaler, duty 4 then 0
      cur_req = "R9";
      pwm_en = 1; mode_sel = 2'd1; load(8'hF8, 8'h04); run_en = 1; run(24);
      run_en = 0; wr_hi = 1; wr_data = 8'h00; cyc(); wr_hi = 0; run_en = 1; run(12);
      ovf_clr = 1; cyc(); ovf_clr = 0;

      // R10: prescaled PWM, exponent 2 then 0
      cur_req = "R10";
      run_en = 0; mode_sel = 2'd0; shape_sel = 3'd2; load(8'h00, 8'h02); run_en = 1; run(40);
      shape_sel = 3'd0; run(12);
      wr_hi = 1; wr_data = 8'h00; cyc(); wr_hi = 0; run(4);

      // R11: frequency generator
      cur_req = "R11";
      run_en = 0; mode_sel = 2'd2; load(8'h00, 8'h03); run_en = 1; run(20);

      // R12: hold mode
      cur_req = "R12";
      mode_sel = 2'd3; run(6);

      // R13: back to counting family
      cur_req = "R13";
      pwm_en = 0; mode_sel = 2'd1; run(3);
      run_en = 0; run(2);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule